// File: doc/BRIEF.md
# Sector Slot DMA Scheduler

This block decides where each incoming CD sector lands in memory. Software programs a 64 KiB aligned base address and arms up to sixteen 4 KiB slots by setting bits in a pending mask. Sector bytes arrive on a valid/ready byte stream. The first byte of each sector carries a start marker and the low bits of the sector number. The block picks the highest armed slot when a sector starts and writes a four-byte header followed by the payload into that slot. When the sector is complete it disarms the slot and raises a completion flag.

Software can only arm slots through the mask register; it can never disarm them there. Clearing the data DMA enable empties the mask and locks it. A sector that finishes after its slot was taken away, with DMA enabled again, is dropped and reported through an overflow flag. The interrupt output is high while either flag is set.

Top module: `sector_slot_dma`

## Requirements
- R1: After reset the base reads 0, the mask reads 0, DMA is disabled, the status register reads 0, `irq` is low, `mem_we` is low and `s_ready` is low.
- R2: A write to the mask register (address 1) ORs bits [15:0] of the data into the mask. Bits written as zero leave the mask unchanged, so a write of zero keeps every pending bit.
- R3: While the enable bit (bit 27 of the control register, address 2) is zero, the mask reads zero and mask writes have no effect. Clearing the enable bit empties the mask.
- R4: The base register (address 0) keeps bits [31:16] and reads back zero in bits [15:0]. Byte k of slot n is written at address base + n*0x1000 + k.
- R5: When a sector starts, the highest pending mask bit selects its slot. Bit 15 is served before lower bits.
- R6: Each sector is 2352 raw bytes. Slot offsets 0 to 2 receive zero, and offset 3 receives the 5-bit sector number zero-extended. Offsets 4 to 2351 receive raw bytes 4 to 2351 at the same offset. Raw bytes 0 to 3 are not stored.
- R7: When the last byte of a sector is accepted, the slot's mask bit is cleared and status bit 26 (address 3) is set.
- R8: Any mask write clears status bit 26. If a completion happens in the same cycle, bit 26 ends up set, and the new mask is (old mask with the completed bit cleared) OR the written bits.
- R9: `s_ready` is low between sectors while the mask is empty. It stays high for the whole of a sector once that sector has started.
- R10: If the sector's slot bit is cleared before the sector ends, no further bytes of that sector are written. If DMA is enabled when the sector ends, status bit 25 is set and bit 26 is not. Any write to the control register clears bit 25.
- R11: `irq` is high exactly when status bit 26 or bit 25 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 base, 1 mask, 2 control, 3 status |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| s_valid | input | 1 | Sector byte valid |
| s_ready | output | 1 | Sector byte accepted when high with `s_valid` |
| s_sof | input | 1 | Marks the first byte of a sector |
| s_secnum | input | 5 | Low bits of the sector number, sampled with the first byte |
| s_data | input | 8 | Sector byte |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| irq | output | 1 | Interrupt, high while completion or overflow is flagged |

## Verification
The two functions that can fall in the same cycle are a software write to the mask register and the completion of a sector. Each one changes both the mask and status bit 26. The bench forces the collision by presenting the final byte of a sector in the same cycle as a mask write. That write re-arms the slot being completed and also arms a new one. The bench then expects bit 26 to stay set and the mask to equal the old mask with the completed bit cleared, ORed with the written bits.

// File: rtl/sdma_pkg.sv
// Shared definitions for the sector slot DMA scheduler.
// Assumes a 32-bit register bus with four word registers.
package sdma_pkg;
    typedef enum logic [1:0] {
        RA_BASE = 2'd0,
        RA_MASK = 2'd1,
        RA_CTRL = 2'd2,
        RA_STAT = 2'd3
    } reg_addr_e;

    localparam int BIT_EN   = 27;   // control: data DMA enable
    localparam int BIT_DONE = 26;   // status: slot filled
    localparam int BIT_OVF  = 25;   // status: sector dropped
endpackage

// File: rtl/sdma_slot_picker.sv
// Priority picker: grants the highest set bit of the pending mask.
// Assumes SLOTS >= 2. Clock and reset serve the embedded check only.
module sdma_slot_picker #(
    parameter int SLOTS = 16,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SLOTS-1:0] pending,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    logic [SLOTS:0]   higher;
    logic [SLOTS-1:0] grant;

    assign higher[SLOTS] = 1'b0;

    // One grant stage per slot: granted if set and nothing above is set.
    for (genvar g = 0; g < SLOTS; g++) begin : g_stage
        assign grant[g]  = pending[g] & ~higher[g+1];
        assign higher[g] = higher[g+1] | pending[g];
    end

    assign any = higher[0];

    // Encode the one-hot grant into a slot index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (grant[i]) idx = IDX_W'(i);
        end
    end

    // R5: at most one slot is ever granted.
    a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
endmodule

// File: rtl/sdma_regs.sv
// Register file: base, set-only pending mask, DMA enable and the two
// sticky status flags. Completion and overflow events come from the writer.
// Assumes one register access per cycle; reads are combinational.
module sdma_regs
    import sdma_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int SLOTS      = 16,
    parameter int SLOT_SHIFT = 12,
    localparam int IDX_W     = $clog2(SLOTS),
    localparam int BASE_W    = ADDR_W - SLOT_SHIFT - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              done,
    input  logic [IDX_W-1:0]  done_slot,
    input  logic              ovf,
    output logic [BASE_W-1:0] base_hi,
    output logic [SLOTS-1:0]  mask,
    output logic              dma_en,
    output logic              flag_done,
    output logic              flag_ovf
);
    logic             wr_base, wr_mask, wr_ctrl;
    logic             en_nxt;
    logic [SLOTS-1:0] clr_bits, set_bits, mask_nxt;

    assign wr_base = bus_we && (bus_addr == RA_BASE);
    assign wr_mask = bus_we && (bus_addr == RA_MASK);
    assign wr_ctrl = bus_we && (bus_addr == RA_CTRL);

    // Next mask: completion clears its bit, writes only set, disable empties.
    always_comb begin
        en_nxt   = wr_ctrl ? bus_wdata[BIT_EN] : dma_en;
        clr_bits = done ? (SLOTS'(1) << done_slot) : '0;
        set_bits = (wr_mask && en_nxt) ? bus_wdata[SLOTS-1:0] : '0;
        mask_nxt = en_nxt ? ((mask & ~clr_bits) | set_bits) : '0;
    end

    // Register state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_hi   <= '0;
            mask      <= '0;
            dma_en    <= 1'b0;
            flag_done <= 1'b0;
            flag_ovf  <= 1'b0;
        end else begin
            if (wr_base) base_hi <= bus_wdata[ADDR_W-1 -: BASE_W];
            mask   <= mask_nxt;
            dma_en <= en_nxt;
            if (done)         flag_done <= 1'b1;
            else if (wr_mask) flag_done <= 1'b0;
            if (ovf)          flag_ovf <= 1'b1;
            else if (wr_ctrl) flag_ovf <= 1'b0;
        end
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_BASE: bus_rdata[ADDR_W-1 -: BASE_W] = base_hi;
            RA_MASK: bus_rdata[SLOTS-1:0] = mask;
            RA_CTRL: bus_rdata[BIT_EN] = dma_en;
            default: begin
                bus_rdata[BIT_DONE] = flag_done;
                bus_rdata[BIT_OVF]  = flag_ovf;
            end
        endcase
    end

    // R3: a disabled block never holds a pending slot.
    a_r3_disabled_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> (mask == '0));
    // R2: a mask write without a completion never drops a pending bit.
    a_r2_set_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mask && !done && dma_en) |=> (($past(mask) & ~mask) == '0));
    // R7: a completion always leaves the done flag set.
    a_r7_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> flag_done);
    // R8: a mask write with no completion drops the done flag.
    a_r8_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mask && !done) |=> !flag_done);
endmodule

// File: rtl/sdma_writer.sv
// Stream-to-memory writer: takes sector bytes, binds each sector to the
// picked slot at its first byte, emits header and payload byte writes and
// reports completion or overflow on the last byte.
// Assumes memory accepts one byte write per cycle and SECTOR_BYTES > HDR_BYTES.
module sdma_writer #(
    parameter int ADDR_W       = 32,
    parameter int SLOTS        = 16,
    parameter int SLOT_SHIFT   = 12,
    parameter int SECTOR_BYTES = 2352,
    parameter int HDR_BYTES    = 4,
    parameter int SEC_W        = 5,
    localparam int IDX_W       = $clog2(SLOTS),
    localparam int BASE_W      = ADDR_W - SLOT_SHIFT - IDX_W,
    localparam int OFF_W       = $clog2(SECTOR_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic              s_sof,
    input  logic [SEC_W-1:0]  s_secnum,
    input  logic [7:0]        s_data,
    input  logic [BASE_W-1:0] base_hi,
    input  logic [SLOTS-1:0]  mask,
    input  logic              dma_en,
    input  logic              pick_any,
    input  logic [IDX_W-1:0]  pick_idx,
    output logic              done,
    output logic              ovf,
    output logic [IDX_W-1:0]  done_slot,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(SECTOR_BYTES - 1);
    localparam logic [OFF_W-1:0] HDR_OFF  = OFF_W'(HDR_BYTES);

    logic             busy;
    logic [OFF_W-1:0] off;
    logic [IDX_W-1:0] slot;
    logic [SEC_W-1:0] secno;
    logic             fire, start, last, live, wr_now;
    logic [IDX_W-1:0] wr_slot;
    logic [OFF_W-1:0] wr_off;
    logic [7:0]       wr_byte;

    assign s_ready = busy | pick_any;
    assign fire    = s_valid & s_ready;
    assign start   = fire & ~busy & s_sof;
    assign last    = fire & busy & (off == LAST_OFF);
    assign live    = mask[slot];

    assign done      = last & live;
    assign ovf       = last & ~live & dma_en;
    assign done_slot = slot;

    // Byte to store: header zeros, sector number, then raw payload.
    always_comb begin
        wr_now  = start | (fire & busy & live);
        wr_slot = busy ? slot : pick_idx;
        wr_off  = busy ? off : '0;
        if (wr_off < HDR_OFF) begin
            wr_byte = (wr_off == HDR_OFF - 1'b1) ? 8'(secno) : 8'h00;
        end else begin
            wr_byte = s_data;
        end
    end

    // Sector tracking: bind slot and sector number at start, count bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            off   <= '0;
            slot  <= '0;
            secno <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            off   <= OFF_W'(1);
            slot  <= pick_idx;
            secno <= s_secnum;
        end else if (last) begin
            busy <= 1'b0;
            off  <= '0;
        end else if (fire && busy) begin
            off <= off + 1'b1;
        end
    end

    // Registered memory write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= wr_now;
            if (wr_now) begin
                mem_addr  <= {base_hi, wr_slot, SLOT_SHIFT'(wr_off)};
                mem_wdata <= wr_byte;
            end
        end
    end

    // R5: a new sector never skips a higher pending slot.
    a_r5_highest_first: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ((mask >> pick_idx) == SLOTS'(1)));
    // R6: no write ever leaves the sector area of a slot.
    a_r6_offset_range: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[SLOT_SHIFT-1:0] < SLOT_SHIFT'(SECTOR_BYTES)));
    // R10: a dropped sector produces no completion and no write in its last cycle.
    a_r10_no_overflow_write: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (!done && !wr_now));
endmodule

// File: rtl/sector_slot_dma.sv
// Top of the sector slot DMA scheduler: register file, slot picker and
// stream writer. Assumes a memory that takes one byte write per cycle.
module sector_slot_dma #(
    parameter int ADDR_W       = 32,
    parameter int DATA_W       = 32,
    parameter int SLOTS        = 16,
    parameter int SLOT_SHIFT   = 12,
    parameter int SECTOR_BYTES = 2352,
    parameter int HDR_BYTES    = 4,
    parameter int SEC_W        = 5,
    localparam int IDX_W       = $clog2(SLOTS),
    localparam int BASE_W      = ADDR_W - SLOT_SHIFT - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic              s_sof,
    input  logic [SEC_W-1:0]  s_secnum,
    input  logic [7:0]        s_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              irq
);
    logic [BASE_W-1:0] base_hi;
    logic [SLOTS-1:0]  mask;
    logic              dma_en, flag_done, flag_ovf;
    logic              done, ovf, pick_any;
    logic [IDX_W-1:0]  done_slot, pick_idx;

    sdma_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOTS(SLOTS), .SLOT_SHIFT(SLOT_SHIFT)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done(done),
        .done_slot(done_slot), .ovf(ovf), .base_hi(base_hi), .mask(mask),
        .dma_en(dma_en), .flag_done(flag_done), .flag_ovf(flag_ovf)
    );

    sdma_slot_picker #(.SLOTS(SLOTS)) pick_i (
        .clk(clk), .rst_n(rst_n), .pending(mask), .any(pick_any), .idx(pick_idx)
    );

    sdma_writer #(
        .ADDR_W(ADDR_W), .SLOTS(SLOTS), .SLOT_SHIFT(SLOT_SHIFT),
        .SECTOR_BYTES(SECTOR_BYTES), .HDR_BYTES(HDR_BYTES), .SEC_W(SEC_W)
    ) wr_i (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
        .s_sof(s_sof), .s_secnum(s_secnum), .s_data(s_data), .base_hi(base_hi),
        .mask(mask), .dma_en(dma_en), .pick_any(pick_any), .pick_idx(pick_idx),
        .done(done), .ovf(ovf), .done_slot(done_slot), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // Interrupt is the OR of the two sticky flags.
    assign irq = flag_done | flag_ovf;

    // R11: interrupt rises one cycle after a completion.
    a_r11_irq_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> irq);
    // R9: the stream stalls between sectors while nothing is pending.
    a_r9_stall_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0 && !$past(s_ready)) |-> !s_ready);
endmodule

// File: tb/sector_slot_dma_tb.sv
// Scoreboard bench: driver pushes expected memory writes, monitor pops them.
module sector_slot_dma_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NBYTES     = 2352;
    localparam logic [31:0] BASE = 32'h0003_0000;

    typedef struct packed {
        logic [31:0] a;
        logic [7:0]  d;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        s_valid = 1'b0, s_sof = 1'b0;
    logic        s_ready;
    logic [4:0]  s_secnum = '0;
    logic [7:0]  s_data = '0;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        irq;

    int   n_chk = 0, n_fail = 0;
    exp_t q[$];

    sector_slot_dma dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .s_valid(s_valid),
        .s_ready(s_ready), .s_sof(s_sof), .s_secnum(s_secnum), .s_data(s_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Monitor: every memory write must match the head of the queue.
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (q.size() == 0) begin
                chk(1'b0, "R10", "unexpected write", mem_addr, 32'hxxxxxxxx);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(mem_addr == e.a && mem_wdata == e.d, "R6", "write addr/data",
                    {mem_addr[23:0], mem_wdata}, {e.a[23:0], e.d});
            end
        end
    end

    function automatic logic [7:0] raw(int i, logic [7:0] seed);
        return 8'(seed + i * 7);
    endfunction

    function automatic logic [7:0] stored(int i, logic [4:0] sec, logic [7:0] seed);
        if (i < 3) return 8'h00;
        if (i == 3) return {3'b000, sec};
        return raw(i, seed);
    endfunction

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Driver: sends raw bytes [first, stop) and queues expected writes.
    task automatic send_range(input int first, input int stop, input logic [4:0] sec,
                              input int slot, input bit expect_wr, input logic [7:0] seed);
        for (int i = first; i < stop; i++) begin
            @(negedge clk);
            s_valid = 1'b1; s_sof = (i == 0); s_secnum = sec; s_data = raw(i, seed);
            while (!s_ready) @(negedge clk);
            if (expect_wr) q.push_back({BASE + 32'(slot) * 32'h1000 + 32'(i), stored(i, sec, seed)});
            @(posedge clk);
        end
        @(negedge clk);
        s_valid = 1'b0; s_sof = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", 0, 1);
        report();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        reg_rd(2'd0, v); chk(v == 0, "R1", "base", v, 0);
        reg_rd(2'd1, v); chk(v == 0, "R1", "mask", v, 0);
        reg_rd(2'd2, v); chk(v == 0, "R1", "ctrl", v, 0);
        reg_rd(2'd3, v); chk(v == 0, "R1", "status", v, 0);
        chk(!irq && !mem_we && !s_ready, "R1", "irq/we/ready", {irq, mem_we, s_ready}, 0);

        // R3: mask writes ignored while disabled
        reg_wr(2'd1, 32'h0000_0001);
        reg_rd(2'd1, v); chk(v == 0, "R3", "mask while disabled", v, 0);

        // R4: base low half ignored
        reg_wr(2'd0, 32'h0003_ABCD);
        reg_rd(2'd0, v); chk(v == BASE, "R4", "base readback", v, BASE);

        // R2: set-only mask
        reg_wr(2'd2, 32'h0800_0000);
        reg_wr(2'd1, 32'h0000_8001);
        reg_wr(2'd1, 32'h0000_0100);
        reg_rd(2'd1, v); chk(v == 32'h8101, "R2", "set-only", v, 32'h8101);
        reg_wr(2'd1, 32'h0);
        reg_rd(2'd1, v); chk(v == 32'h8101, "R2", "zero write keeps", v, 32'h8101);

        // R5 R6 R7: first sector goes to slot 15
        send_range(0, NBYTES, 5'h05, 15, 1'b1, 8'h11);
        repeat (2) @(negedge clk);
        reg_rd(2'd1, v); chk(v == 32'h0101, "R7", "slot 15 cleared", v, 32'h0101);
        reg_rd(2'd3, v); chk(v == 32'h0400_0000, "R7", "done flag", v, 32'h0400_0000);
        chk(irq, "R11", "irq on done", irq, 1);

        // R8: mask write clears done flag, mask kept
        reg_wr(2'd1, 32'h0);
        reg_rd(2'd3, v); chk(v == 0, "R8", "done cleared", v, 0);
        chk(!irq, "R11", "irq low", irq, 0);
        reg_rd(2'd1, v); chk(v == 32'h0101, "R8", "mask kept", v, 32'h0101);

        // R5: then slot 8, then slot 0
        send_range(0, NBYTES, 5'h1F, 8, 1'b1, 8'h40);
        send_range(0, NBYTES, 5'h00, 0, 1'b1, 8'hA5);
        repeat (2) @(negedge clk);
        reg_rd(2'd1, v); chk(v == 0, "R5", "all slots served", v, 0);
        chk(q.size() == 0, "R6", "all writes seen", q.size(), 0);

        // R9: stall while nothing pending
        @(negedge clk); s_valid = 1'b1; s_sof = 1'b1;
        #1 chk(!s_ready, "R9", "ready with empty mask", s_ready, 0);
        @(negedge clk); s_valid = 1'b0; s_sof = 1'b0;
        reg_wr(2'd1, 32'h0);

        // R10: slot removed mid-sector, overflow at the end
        reg_wr(2'd1, 32'h0000_0004);
        send_range(0, 100, 5'h09, 2, 1'b1, 8'h33);
        reg_wr(2'd2, 32'h0);
        reg_rd(2'd1, v); chk(v == 0, "R3", "disable empties mask", v, 0);
        #1 chk(s_ready, "R9", "ready mid-sector", s_ready, 1);
        reg_wr(2'd2, 32'h0800_0000);
        send_range(100, NBYTES, 5'h09, 2, 1'b0, 8'h33);
        repeat (2) @(negedge clk);
        reg_rd(2'd3, v); chk(v == 32'h0200_0000, "R10", "overflow flag only", v, 32'h0200_0000);
        chk(irq, "R11", "irq on overflow", irq, 1);
        reg_wr(2'd2, 32'h0800_0000);
        reg_rd(2'd3, v); chk(v == 0, "R10", "ctrl write clears overflow", v, 0);

        // R8: completion and mask write in the same cycle
        reg_wr(2'd1, 32'h0000_0009);
        send_range(0, NBYTES - 1, 5'h12, 3, 1'b1, 8'h77);
        @(negedge clk);
        s_valid = 1'b1; s_sof = 1'b0; s_data = raw(NBYTES - 1, 8'h77);
        bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 32'h0000_000A;
        q.push_back({BASE + 32'h3000 + 32'(NBYTES - 1), raw(NBYTES - 1, 8'h77)});
        @(negedge clk);
        s_valid = 1'b0; bus_we = 1'b0;
        reg_rd(2'd3, v); chk(v == 32'h0400_0000, "R8", "done wins collision", v, 32'h0400_0000);
        reg_rd(2'd1, v); chk(v == 32'h000B, "R8", "collision mask", v, 32'h000B);

        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R6", "queue drained", q.size(), 0);
        report();
    end
endmodule